// File: doc/BRIEF.md
# SMBus bus timing monitor

This block watches the clock and data lines of a two-wire SMBus segment from the side and never drives them. Both lines are synchronized to a fast system clock and filtered. START and STOP conditions are recognised from the filtered lines, and the block measures the intervals between line events in system clock cycles. Each interval is compared against a limit that is fixed when the design is built. Every limit is written in nanoseconds and converted to cycles at elaboration from the system clock frequency parameter.

Two kinds of event abort the transaction the monitor holds open. One is a clock-low phase that lasts too long. The other is a long stretch with both lines high while a transaction is open. Each of these raises a one-cycle pulse. A single control bit, clear by default, turns both of these checks off. The monitor also adds up the clock-low time that goes beyond the controller's nominal low period, from the first START of a message to its STOP, and raises a sticky flag when that total passes its budget. A second control bit masks this check. Further sticky flags report a short bus-free gap, short START hold, repeated-START setup or STOP setup times, and a short data setup time. All flags stay set until the clear input is pulsed. A status output shows whether a transaction is open.

Top module: `smb_timing_monitor`

## Requirements
- R1: Each line passes a two-flop synchronizer and a filter of FILT_LEN (default 3) samples. A level held for fewer than FILT_LEN cycles has no effect on any output.
- R2: START is the filtered SDA falling while SCL is high, and STOP is SDA rising while SCL is high. `busy` goes to 1 after a START and to 0 after a STOP. An SDA change while SCL is low does not change `busy`.
- R3: An SCL low phase longer than TMO cycles gives exactly one `tmo_pulse` and clears `busy`. A low phase of exactly TMO cycles gives no pulse.
- R4: While `busy` is 1, SCL and SDA both high for more than IDLE cycles gives exactly one `idle_rst_pulse` and clears `busy`. A shorter stretch gives no pulse.
- R5: While `dis_tmo` is 1, neither `tmo_pulse` nor `idle_rst_pulse` is raised, and neither condition clears `busy`.
- R6: The stretch sum is cleared by a START that arrives while `busy` is 0. A repeated START does not clear it. While `busy` is 1, each low cycle after the first NOM cycles of a low phase adds one to the sum. When the sum goes past SEXT, `sext_viol` is set, unless `dis_sext` is 1.
- R7: A START that comes while `busy` is 0 and fewer than BUF cycles after the previous STOP sets `buf_viol`. The gap is counted from the cycle of the SDA rise to the cycle of the SDA fall.
- R8: `su_viol` is set by any of three short intervals, each measured against SU cycles: from START to the next SCL fall, from an SCL rise to a repeated START, or from an SCL rise to a STOP.
- R9: While `busy` is 1, an SCL rise that comes fewer than DSU cycles after the last SDA change sets `dsu_viol`.
- R10: Reset clears every output. Once a flag is set, it stays at 1 until `clr_flags` is sampled high, and it reads 0 on the cycle after that.
- R11: Each limit in cycles is ceil(T_ns × CLK_KHZ / 10^6). The defaults, at 125 MHz, give BUF = 588, SU = 33 and DSU = 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| dis_tmo | input | 1 | 1 disables the clock-low timeout and the idle reset |
| dis_sext | input | 1 | 1 masks the cumulative stretch check |
| clr_flags | input | 1 | Clears all sticky violation flags |
| tmo_pulse | output | 1 | One-cycle clock-low timeout pulse |
| idle_rst_pulse | output | 1 | One-cycle idle-high reset pulse |
| busy | output | 1 | Transaction open |
| sext_viol | output | 1 | Sticky cumulative stretch violation |
| buf_viol | output | 1 | Sticky bus-free time violation |
| su_viol | output | 1 | Sticky START hold / repeated-START setup / STOP setup violation |
| dsu_viol | output | 1 | Sticky data setup violation |

## Verification
The limits given in milliseconds would take millions of cycles to reach. The bench therefore builds the monitor with short time limits for timeout, idle, stretch and nominal low, and keeps the default bus-free and setup limits. It can then drive each interval to exactly the limit and to one cycle past it. The hardest cases are a stretch sum carried across a repeated START, and a filter that is too short. In the second case, the only thing that can be seen is that an SDA glitch during SCL high would fake a STOP followed by a START. The bench brings both about by scripting whole transactions bit by bit. For the glitch, a false STOP and START would show up through the bus-free flag.

// File: rtl/smb_mon_pkg.sv
package smb_mon_pkg;

  // ceil(t_ns * f_khz / 1e6), evaluated at elaboration
  function automatic int unsigned ns2cyc(longint unsigned t_ns, longint unsigned f_khz);
    longint unsigned prod;
    prod = t_ns * f_khz;
    return 32'((prod + 64'd999_999) / 64'd1_000_000);
  endfunction

  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
    logic scl_fall;
    logic sda_edge;
  } bus_evt_t;

endpackage

// File: rtl/smb_glitch_filter.sv
module smb_glitch_filter #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  logic [1:0]          sync_q;
  logic [FILT_LEN-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      clean  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
      if (&hist_q)       clean <= 1'b1;
      else if (~|hist_q) clean <= 1'b0;
    end
  end
endmodule

// File: rtl/smb_evt_detect.sv
module smb_evt_detect import smb_mon_pkg::*; (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl,
  input  logic     sda,
  output bus_evt_t evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  always_comb begin
    evt.start    = scl_q & scl & sda_q & ~sda;
    evt.stop     = scl_q & scl & ~sda_q & sda;
    evt.scl_rise = ~scl_q & scl;
    evt.scl_fall = scl_q & ~scl;
    evt.sda_edge = sda_q ^ sda;
  end
endmodule

// File: rtl/smb_phase_timers.sv
module smb_phase_timers #(
  parameter int unsigned TMO_CYC  = 4375000,
  parameter int unsigned IDLE_CYC = 6250000,
  parameter int unsigned NOM_CYC  = 163,
  parameter int unsigned SEXT_CYC = 3125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  input  logic busy,
  input  logic start_init,
  input  logic dis_tmo,
  input  logic dis_sext,
  output logic tmo_hit,
  output logic idle_hit,
  output logic sext_over
);
  localparam int unsigned LW = $clog2(TMO_CYC + 2);
  localparam int unsigned IW = $clog2(IDLE_CYC + 2);
  localparam int unsigned SW = $clog2(SEXT_CYC + 2);

  logic [LW-1:0] low_cnt;
  logic [IW-1:0] idle_cnt;
  logic [SW-1:0] ext_acc;
  logic          both_hi, ext_inc;

  assign both_hi = scl & sda;
  assign ext_inc = busy & ~scl & (32'(low_cnt) >= NOM_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      idle_cnt <= '0;
      ext_acc  <= '0;
    end else begin
      if (scl)                                low_cnt <= '0;
      else if (low_cnt != LW'(TMO_CYC + 1))   low_cnt <= low_cnt + 1'b1;

      if (!both_hi)                           idle_cnt <= '0;
      else if (idle_cnt != IW'(IDLE_CYC + 1)) idle_cnt <= idle_cnt + 1'b1;

      if (start_init)                                    ext_acc <= '0;
      else if (ext_inc && ext_acc != SW'(SEXT_CYC + 1))  ext_acc <= ext_acc + 1'b1;
    end
  end

  assign tmo_hit   = ~scl & (32'(low_cnt) == TMO_CYC) & ~dis_tmo;
  assign idle_hit  = busy & both_hi & (32'(idle_cnt) == IDLE_CYC) & ~dis_tmo;
  assign sext_over = ext_inc & (32'(ext_acc) == SEXT_CYC) & ~dis_sext;
endmodule

// File: rtl/smb_setup_chk.sv
module smb_setup_chk import smb_mon_pkg::*; #(
  parameter int unsigned BUF_CYC = 588,
  parameter int unsigned SU_CYC  = 33,
  parameter int unsigned DSU_CYC = 7
) (
  input  logic     clk,
  input  logic     rst_n,
  input  bus_evt_t evt,
  input  logic     busy,
  output logic     buf_bad,
  output logic     su_bad,
  output logic     dsu_bad
);
  localparam int unsigned BW = $clog2(BUF_CYC + 2);
  localparam int unsigned HW = $clog2(SU_CYC + 2);
  localparam int unsigned DW = $clog2(DSU_CYC + 2);

  logic [BW-1:0] buf_cnt;
  logic [HW-1:0] hi_cnt, st_cnt;
  logic [DW-1:0] sda_cnt, sda_age;
  logic          buf_arm, hold_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_cnt   <= BW'(BUF_CYC);
      hi_cnt    <= HW'(SU_CYC);
      st_cnt    <= HW'(SU_CYC);
      sda_cnt   <= DW'(DSU_CYC);
      buf_arm   <= 1'b0;
      hold_pend <= 1'b0;
    end else begin
      if (evt.stop)                          buf_cnt <= BW'(1);
      else if (buf_cnt != BW'(BUF_CYC))      buf_cnt <= buf_cnt + 1'b1;
      if (evt.scl_rise)                      hi_cnt  <= HW'(1);
      else if (hi_cnt != HW'(SU_CYC))        hi_cnt  <= hi_cnt + 1'b1;
      if (evt.start)                         st_cnt  <= HW'(1);
      else if (st_cnt != HW'(SU_CYC))        st_cnt  <= st_cnt + 1'b1;
      if (evt.sda_edge)                      sda_cnt <= DW'(1);
      else if (sda_cnt != DW'(DSU_CYC))      sda_cnt <= sda_cnt + 1'b1;

      if (evt.stop)       buf_arm <= 1'b1;
      else if (evt.start) buf_arm <= 1'b0;
      if (evt.start)         hold_pend <= 1'b1;
      else if (evt.scl_fall) hold_pend <= 1'b0;
    end
  end

  assign sda_age = evt.sda_edge ? '0 : sda_cnt;
  assign buf_bad = evt.start & ~busy & buf_arm & (32'(buf_cnt) < BUF_CYC);
  assign su_bad  = ((evt.start | evt.stop) & (32'(hi_cnt) < SU_CYC)) |
                   (evt.scl_fall & hold_pend & (32'(st_cnt) < SU_CYC));
  assign dsu_bad = evt.scl_rise & busy & (32'(sda_age) < DSU_CYC);
endmodule

// File: rtl/smb_timing_monitor.sv
module smb_timing_monitor import smb_mon_pkg::*; #(
  parameter longint unsigned CLK_KHZ      = 125_000,
  parameter longint unsigned T_LOW_TMO_NS = 35_000_000,
  parameter longint unsigned T_IDLE_NS    = 50_000_000,
  parameter longint unsigned T_SEXT_NS    = 25_000_000,
  parameter longint unsigned T_NOM_LOW_NS = 1_300,
  parameter longint unsigned T_BUF_NS     = 4_700,
  parameter longint unsigned T_SU_NS      = 260,
  parameter longint unsigned T_DSU_NS     = 50,
  parameter int unsigned     FILT_LEN     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic dis_tmo,
  input  logic dis_sext,
  input  logic clr_flags,
  output logic tmo_pulse,
  output logic idle_rst_pulse,
  output logic busy,
  output logic sext_viol,
  output logic buf_viol,
  output logic su_viol,
  output logic dsu_viol
);
  localparam int unsigned TMO_CYC  = ns2cyc(T_LOW_TMO_NS, CLK_KHZ);
  localparam int unsigned IDLE_CYC = ns2cyc(T_IDLE_NS, CLK_KHZ);
  localparam int unsigned SEXT_CYC = ns2cyc(T_SEXT_NS, CLK_KHZ);
  localparam int unsigned NOM_CYC  = ns2cyc(T_NOM_LOW_NS, CLK_KHZ);
  localparam int unsigned BUF_CYC  = ns2cyc(T_BUF_NS, CLK_KHZ);
  localparam int unsigned SU_CYC   = ns2cyc(T_SU_NS, CLK_KHZ);
  localparam int unsigned DSU_CYC  = ns2cyc(T_DSU_NS, CLK_KHZ);

  logic [1:0] raw_l, clean_l;
  logic       f_scl, f_sda, ev_start, ev_stop, start_init;
  logic       tmo_hit, idle_hit, sext_over, buf_bad, su_bad, dsu_bad;
  bus_evt_t   evt;

  assign raw_l = {sda_in, scl_in};

  for (genvar i = 0; i < 2; i++) begin : g_filt
    smb_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw(raw_l[i]), .clean(clean_l[i]));
  end

  assign f_scl = clean_l[0];
  assign f_sda = clean_l[1];

  smb_evt_detect u_evt (.clk(clk), .rst_n(rst_n), .scl(f_scl), .sda(f_sda), .evt(evt));

  assign ev_start   = evt.start;
  assign ev_stop    = evt.stop;
  assign start_init = ev_start & ~busy;

  smb_phase_timers #(
    .TMO_CYC(TMO_CYC), .IDLE_CYC(IDLE_CYC), .NOM_CYC(NOM_CYC), .SEXT_CYC(SEXT_CYC)
  ) u_tmr (
    .clk(clk), .rst_n(rst_n), .scl(f_scl), .sda(f_sda), .busy(busy),
    .start_init(start_init), .dis_tmo(dis_tmo), .dis_sext(dis_sext),
    .tmo_hit(tmo_hit), .idle_hit(idle_hit), .sext_over(sext_over));

  smb_setup_chk #(.BUF_CYC(BUF_CYC), .SU_CYC(SU_CYC), .DSU_CYC(DSU_CYC)) u_su (
    .clk(clk), .rst_n(rst_n), .evt(evt), .busy(busy),
    .buf_bad(buf_bad), .su_bad(su_bad), .dsu_bad(dsu_bad));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy           <= 1'b0;
      tmo_pulse      <= 1'b0;
      idle_rst_pulse <= 1'b0;
      sext_viol      <= 1'b0;
      buf_viol       <= 1'b0;
      su_viol        <= 1'b0;
      dsu_viol       <= 1'b0;
    end else begin
      if (tmo_hit || idle_hit || ev_stop) busy <= 1'b0;
      else if (ev_start)                  busy <= 1'b1;
      tmo_pulse      <= tmo_hit;
      idle_rst_pulse <= idle_hit;
      sext_viol      <= (sext_viol & ~clr_flags) | sext_over;
      buf_viol       <= (buf_viol  & ~clr_flags) | buf_bad;
      su_viol        <= (su_viol   & ~clr_flags) | su_bad;
      dsu_viol       <= (dsu_viol  & ~clr_flags) | dsu_bad;
    end
  end
endmodule

// File: rtl/smb_timing_monitor_chk.sv
module smb_timing_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic dis_tmo,
  input logic clr_flags,
  input logic ev_start,
  input logic tmo_pulse,
  input logic idle_rst_pulse,
  input logic busy,
  input logic sext_viol,
  input logic buf_viol,
  input logic su_viol,
  input logic dsu_viol
);
  p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ev_start));

  p_tmo_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |=> !tmo_pulse);

  p_tmo_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |-> !busy);

  p_idle_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idle_rst_pulse |-> (!busy && $past(busy)));

  p_idle_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idle_rst_pulse |=> !idle_rst_pulse);

  p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_pulse || idle_rst_pulse) |-> !$past(dis_tmo));

  p_sext_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sext_viol && !clr_flags) |=> sext_viol);

  p_buf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_viol && !clr_flags) |=> buf_viol);

  p_su_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (su_viol && !clr_flags) |=> su_viol);

  p_dsu_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dsu_viol && !clr_flags) |=> dsu_viol);
endmodule

bind smb_timing_monitor smb_timing_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dis_tmo(dis_tmo), .clr_flags(clr_flags),
  .ev_start(ev_start), .tmo_pulse(tmo_pulse), .idle_rst_pulse(idle_rst_pulse),
  .busy(busy), .sext_viol(sext_viol), .buf_viol(buf_viol),
  .su_viol(su_viol), .dsu_viol(dsu_viol));

// File: tb/smb_timing_monitor_tb.sv
`timescale 1ns/1ps
module smb_timing_monitor_tb;
  // limits in cycles at 125 MHz: ceil(ns * 125 / 1000)  (R11)
  function automatic int cyc(int ns);
    return (ns * 125 + 999) / 1000;
  endfunction
  localparam int TMO_C  = cyc(20000);
  localparam int IDLE_C = cyc(30000);
  localparam int SEXT_C = cyc(3000);
  localparam int NOM_C  = cyc(800);
  localparam int BUF_C  = cyc(4700);
  localparam int SU_C   = cyc(260);
  localparam int DSU_C  = cyc(50);

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, dis_tmo = 1'b0, dis_sext = 1'b0, clr = 1'b0;
  logic tmo_pulse, idle_rst_pulse, busy, sext_viol, buf_viol, su_viol, dsu_viol;
  int total = 0, bad = 0, n_tmo = 0, n_idle = 0;

  always #4 clk = ~clk;

  smb_timing_monitor #(
    .T_LOW_TMO_NS(20000), .T_IDLE_NS(30000), .T_SEXT_NS(3000), .T_NOM_LOW_NS(800)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .dis_tmo(dis_tmo),
    .dis_sext(dis_sext), .clr_flags(clr), .tmo_pulse(tmo_pulse),
    .idle_rst_pulse(idle_rst_pulse), .busy(busy), .sext_viol(sext_viol),
    .buf_viol(buf_viol), .su_viol(su_viol), .dsu_viol(dsu_viol));

  always @(posedge clk) begin
    if (tmo_pulse) n_tmo++;
    if (idle_rst_pulse) n_idle++;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_clr();
    clr = 1'b1; step(1); clr = 1'b0; step(1);
  endtask

  task automatic do_start(int hold);
    sda = 1'b0; step(hold); scl = 1'b0;
  endtask
  task automatic do_bit(int setup, int low, int high);
    step(low - setup); sda = ~sda; step(setup); scl = 1'b1; step(high); scl = 1'b0;
  endtask
  task automatic do_stop(int su);
    sda = 1'b0; step(40); scl = 1'b1; step(su); sda = 1'b1;
  endtask
  task automatic do_rstart(int su);
    sda = 1'b1; step(40); scl = 1'b1; step(su); sda = 1'b0; step(40); scl = 1'b0;
  endtask

  task automatic run_vec(int kind, int arg);
    case (kind)
      0: begin do_start(arg); do_bit(20, 100, 100); do_stop(40); end
      1: begin do_start(40); do_bit(20, 100, 100); do_stop(arg); end
      2: begin do_start(40); do_bit(20, 100, 100); do_rstart(arg);
               do_bit(20, 100, 100); do_stop(40); end
      3: begin do_start(40); do_bit(arg, 100, 100); do_stop(40); end
      4: begin do_start(40); do_bit(20, 100, 100); do_stop(40); step(arg);
               do_start(40); do_bit(20, 100, 100); do_stop(40); end
      5: begin do_start(40); do_bit(20, arg, 100); do_stop(40); end
      6: begin do_start(40); do_bit(20, NOM_C + arg / 2, 100);
               do_bit(20, NOM_C + arg / 2, 100); do_stop(40); end
      default: begin do_start(40); do_bit(20, NOM_C + arg, 100); do_rstart(40);
               do_bit(20, NOM_C + arg, 100); do_stop(40); end
    endcase
    step(700);
  endtask

  // kind: 0 START hold, 1 STOP setup, 2 repeated-START setup (R8);
  // 3 data setup (R9); 4 bus free (R7); 5 low timeout (R3);
  // 6 stretch sum, 7 stretch sum across repeated START (R6). Boundaries from R11.
  localparam int NV = 15;
  localparam int VK[NV] = '{0, 0, 1, 1, 2, 2, 3, 3, 4, 4, 5, 5, 6, 6, 7};
  localparam int VA[NV] = '{SU_C-1, SU_C, SU_C-1, SU_C, SU_C-1, SU_C, DSU_C-1, DSU_C,
                            BUF_C-1, BUF_C, TMO_C, TMO_C+1, SEXT_C+1, SEXT_C-1, 200};
  localparam int VE[NV] = '{1, 0, 1, 0, 1, 0, 1, 0, 1, 0, 0, 1, 1, 0, 1};

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(5); rst_n = 1'b1; step(10);
    // R10 reset state
    chk("R10 reset busy", int'(busy), 0);
    chk("R10 reset flags", int'({sext_viol, buf_viol, su_viol, dsu_viol}), 0);
    chk("R10 reset pulses", n_tmo + n_idle, 0);

    for (int i = 0; i < NV; i++) begin
      int t0;
      pulse_clr();
      t0 = n_tmo;
      run_vec(VK[i], VA[i]);
      case (VK[i])
        0, 1, 2: chk($sformatf("R8 vec%0d su_viol", i), int'(su_viol), VE[i]);
        3:       chk($sformatf("R9 vec%0d dsu_viol", i), int'(dsu_viol), VE[i]);
        4:       chk($sformatf("R7 vec%0d buf_viol", i), int'(buf_viol), VE[i]);
        5:       chk($sformatf("R3 vec%0d tmo pulses", i), n_tmo - t0, VE[i]);
        default: chk($sformatf("R6 vec%0d sext_viol", i), int'(sext_viol), VE[i]);
      endcase
      chk($sformatf("R2 vec%0d idle after STOP", i), int'(busy), 0);
    end

    // R1: 2-cycle SDA glitch while SCL high would fake STOP+START -> buf_viol
    pulse_clr();
    do_start(40); step(50); scl = 1'b1; step(20);
    sda = 1'b1; step(2); sda = 1'b0; step(20);
    chk("R1 glitch ignored busy", int'(busy), 1);
    scl = 1'b0; do_stop(40); step(700);
    chk("R1 glitch no buf_viol", int'(buf_viol), 0);
    chk("R1 glitch no su_viol", int'(su_viol), 0);

    // R2 + R4: SDA moves with SCL low, then idle high while open
    do_start(40); step(20);
    chk("R2 busy after START", int'(busy), 1);
    do_bit(20, 100, 100); sda = 1'b1; step(20);
    chk("R2 SDA change while SCL low keeps busy", int'(busy), 1);
    scl = 1'b1; step(IDLE_C - 750);
    chk("R4 short idle no pulse", n_idle, 0);
    chk("R4 short idle busy kept", int'(busy), 1);
    step(800);
    chk("R4 idle pulse", n_idle, 1);
    chk("R4 idle clears busy", int'(busy), 0);
    step(700);

    // R5: mask both abort checks
    dis_tmo = 1'b1;
    do_start(40); do_bit(20, 100, 100); sda = 1'b1; step(20);
    scl = 1'b1; step(IDLE_C + 100);
    chk("R5 idle masked", n_idle, 1);
    chk("R5 busy kept after idle", int'(busy), 1);
    scl = 1'b0; step(TMO_C + 100);
    chk("R5 tmo masked", n_tmo, 1);
    chk("R5 busy kept after long low", int'(busy), 1);
    do_stop(40); step(700);
    dis_tmo = 1'b0;
    chk("R2 busy cleared by STOP", int'(busy), 0);

    // R6 mask
    pulse_clr();
    dis_sext = 1'b1; run_vec(6, SEXT_C + 50); dis_sext = 1'b0;
    chk("R6 dis_sext masks", int'(sext_viol), 0);

    // R10 sticky and clear
    pulse_clr();
    run_vec(0, 10); step(500);
    chk("R10 flag holds", int'(su_viol), 1);
    clr = 1'b1; step(1); clr = 1'b0;
    chk("R10 clear takes effect", int'(su_viol), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule